// File: doc/BRIEF.md
# Byte-Interleaved Cache Line Fill Engine

This block fetches one 64-byte cache line from a rank of eight byte-wide DRAM devices that together drive a 64-bit data bus. It takes a physical line address and splits it into bank, row and column fields. It then sends one column read per beat, with the same command going to every device at once. Consecutive bytes of the address space sit on consecutive devices, so every 64-bit beat carries eight neighbouring bytes, one from each device. Each read therefore moves the byte column forward by eight.

Device timing is hidden behind a beat-valid strobe. When the strobe is high, the eight device lanes on the data bus are written into the next 64-bit slot of the line buffer. After the eighth beat is stored, the block raises a one-cycle done pulse, and the whole 512-bit line is on the output. Only one line is in flight at a time: a request that arrives while a fill is under way is dropped, and so is a beat that arrives with no fill under way.

Top module: `lf_line_fill`

## Requirements
- R1: While reset is high and in the first cycle after it is released, `busy`, `cmd_valid` and `line_done` are low.
- R2: The command fields are taken from the request address as follows. Bank is `req_addr[13:11]`. Row is `req_addr[27:14]`. The start column is `req_addr[10:0]` with its six low bits forced to zero. With the default parameters the byte-in-line bits of the address are ignored.
- R3: If `req_valid` is high at a clock edge where `busy` is low, a fill starts. In the next cycle `busy` is high and `cmd_valid` is high, carrying the start column.
- R4: Each fill produces exactly eight consecutive cycles of `cmd_valid`. The column goes up by 8 from one command to the next, and bank and row stay the same.
- R5: Beats are numbered n = 0..7 in the order they are captured. For beat n, the byte on data lanes `8k+7:8k` (device k) is placed at line bits `64n+8k+7:64n+8k`.
- R6: `line_done` is high for exactly one cycle. That cycle follows the clock edge that stores the eighth beat. In it, `line_data` holds the complete line and `busy` is low.
- R7: A `beat_valid` that arrives while `busy` is low stores nothing, does not raise `line_done`, and does not count toward the next fill.
- R8: A `req_valid` that arrives while `busy` is high starts no commands and leaves the current fill unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a line fill for `req_addr` |
| req_addr | input | 28 | Physical line address |
| busy | output | 1 | A fill is in progress |
| cmd_valid | output | 1 | Column read command valid for all devices |
| cmd_bank | output | 3 | Bank of the current command |
| cmd_row | output | 14 | Row of the current command |
| cmd_col | output | 11 | Byte column of the current command |
| beat_valid | input | 1 | Devices are presenting a beat on `beat_data` |
| beat_data | input | 64 | Eight device lanes, device k on bits 8k+7:8k |
| line_done | output | 1 | One-cycle pulse: line complete |
| line_data | output | 512 | Assembled cache line |

## Verification
Each fault in the beat slot counter shows up at `line_done`, which still holds one whole line of latency. A slot index that is off by one makes `line_done` come early or late. A slot that is skipped leaves stale bytes in one 64-bit section of `line_data`. A slot that is written twice overwrites a section of `line_data`. A fault in the column counter or the decode shows up on `cmd_col`, `cmd_bank` or `cmd_row` at the first wrong command. That is at most eight cycles after the request. A gate that fails to block idle beats or mid-fill requests shows up as extra commands, or as a line whose beats sit one slot away from where they belong.

// File: rtl/lf_pkg.sv
package lf_pkg;
  typedef enum logic {
    GATHER_IDLE = 1'b0,
    GATHER_RUN  = 1'b1
  } gather_st_e;

  function automatic int lf_lane_lsb(input int beat, input int lane,
                                     input int beat_w, input int lane_w);
    return beat * beat_w + lane * lane_w;
  endfunction
endpackage

// File: rtl/lf_addr_decode.sv
module lf_addr_decode #(
  parameter int ADDR_W        = 28,
  parameter int COL_LSB       = 0,
  parameter int COL_W         = 11,
  parameter int BANK_LSB      = 11,
  parameter int BANK_W        = 3,
  parameter int ROW_LSB       = 14,
  parameter int ROW_W         = 14,
  parameter int LINE_COL_BITS = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] bank,
  output logic [ROW_W-1:0]  row,
  output logic [COL_W-1:0]  col
);
  localparam logic [COL_W-1:0] ALIGN_MASK = ~COL_W'((1 << LINE_COL_BITS) - 1);

  always_comb begin
    bank = addr[BANK_LSB +: BANK_W];
    row  = addr[ROW_LSB +: ROW_W];
    col  = addr[COL_LSB +: COL_W] & ALIGN_MASK;
  end
endmodule

// File: rtl/lf_cmd_seq.sv
module lf_cmd_seq #(
  parameter int BANK_W   = 3,
  parameter int ROW_W    = 14,
  parameter int COL_W    = 11,
  parameter int BEATS    = 8,
  parameter int COL_STEP = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [BANK_W-1:0] bank_in,
  input  logic [ROW_W-1:0]  row_in,
  input  logic [COL_W-1:0]  col_in,
  output logic              cmd_valid,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ROW_W-1:0]  cmd_row,
  output logic [COL_W-1:0]  cmd_col
);
  localparam int CNT_W = $clog2(BEATS + 1);
  localparam logic [COL_W-1:0] STEP_C = COL_W'(COL_STEP);

  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid <= 1'b0;
      left_q    <= '0;
      cmd_bank  <= '0;
      cmd_row   <= '0;
      cmd_col   <= '0;
    end else if (start) begin
      cmd_valid <= 1'b1;
      left_q    <= CNT_W'(BEATS - 1);
      cmd_bank  <= bank_in;
      cmd_row   <= row_in;
      cmd_col   <= col_in;
    end else if (cmd_valid) begin
      if (left_q == '0) begin
        cmd_valid <= 1'b0;
      end else begin
        left_q  <= left_q - 1'b1;
        cmd_col <= cmd_col + STEP_C;
      end
    end
  end

  // Checker: length of the current run of commands
  logic [CNT_W:0] run_q;
  always_ff @(posedge clk) begin
    if (rst)            run_q <= '0;
    else if (cmd_valid) run_q <= run_q + 1'b1;
    else                run_q <= '0;
  end

  // R4
  run_len_chk: assert property (@(posedge clk) disable iff (rst)
    run_q <= (CNT_W+1)'(BEATS));
  // R4
  run_full_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cmd_valid) |-> run_q == (CNT_W+1)'(BEATS));
  // R4
  col_step_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !start && $past(cmd_valid) && !$past(rst) |-> cmd_col == $past(cmd_col) + STEP_C);
  // R4
  bank_row_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && $past(cmd_valid) && !$past(rst) |-> $stable(cmd_bank) && $stable(cmd_row));
endmodule

// File: rtl/lf_beat_gather.sv
module lf_beat_gather
  import lf_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int LANE_W = 8,
  parameter int BEATS  = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic                        beat_valid,
  input  logic [LANES*LANE_W-1:0]     beat_data,
  output logic                        active,
  output logic                        line_done,
  output logic [BEATS*LANES*LANE_W-1:0] line_data
);
  localparam int BEAT_W = LANES * LANE_W;
  localparam int IDX_W  = (BEATS > 1) ? $clog2(BEATS) : 1;

  gather_st_e       st_q;
  logic [IDX_W-1:0] idx_q;
  logic             capture;
  logic [BEATS-1:0] slot_we;
  logic             last_beat;

  assign capture   = (st_q == GATHER_RUN) && beat_valid;
  assign last_beat = (idx_q == IDX_W'(BEATS - 1));
  assign active    = (st_q == GATHER_RUN);

  for (genvar n = 0; n < BEATS; n++) begin : g_slot_we
    assign slot_we[n] = capture && (idx_q == IDX_W'(n));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= GATHER_IDLE;
      idx_q     <= '0;
      line_done <= 1'b0;
    end else begin
      line_done <= capture && last_beat;
      if (start) begin
        st_q  <= GATHER_RUN;
        idx_q <= '0;
      end else if (capture) begin
        idx_q <= idx_q + 1'b1;
        if (last_beat) st_q <= GATHER_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_data <= '0;
    end else begin
      for (int n = 0; n < BEATS; n++) begin
        for (int k = 0; k < LANES; k++) begin
          if (slot_we[n])
            line_data[lf_lane_lsb(n, k, BEAT_W, LANE_W) +: LANE_W]
              <= beat_data[k*LANE_W +: LANE_W];
        end
      end
    end
  end

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    line_done |=> !line_done);
  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    line_done |-> !active);
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !active && !start && !$past(rst) && $past(!active) |-> $stable(line_data));
endmodule

// File: rtl/lf_line_fill.sv
module lf_line_fill #(
  parameter int ADDR_W     = 28,
  parameter int COL_LSB    = 0,
  parameter int COL_W      = 11,
  parameter int BANK_LSB   = 11,
  parameter int BANK_W     = 3,
  parameter int ROW_LSB    = 14,
  parameter int ROW_W      = 14,
  parameter int CHIPS      = 8,
  parameter int CHIP_W     = 8,
  parameter int LINE_BYTES = 64
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic [ADDR_W-1:0]       req_addr,
  output logic                    busy,
  output logic                    cmd_valid,
  output logic [BANK_W-1:0]       cmd_bank,
  output logic [ROW_W-1:0]        cmd_row,
  output logic [COL_W-1:0]        cmd_col,
  input  logic                    beat_valid,
  input  logic [CHIPS*CHIP_W-1:0] beat_data,
  output logic                    line_done,
  output logic [LINE_BYTES*8-1:0] line_data
);
  localparam int BUS_W         = CHIPS * CHIP_W;
  localparam int BEATS         = (LINE_BYTES * 8) / BUS_W;
  localparam int COL_STEP      = BUS_W / 8;
  localparam int LINE_COL_BITS = $clog2(LINE_BYTES);

  logic              start;
  logic              gather_active;
  logic [BANK_W-1:0] dec_bank;
  logic [ROW_W-1:0]  dec_row;
  logic [COL_W-1:0]  dec_col;

  assign busy  = cmd_valid | gather_active;
  assign start = req_valid & ~busy;

  lf_addr_decode #(
    .ADDR_W(ADDR_W), .COL_LSB(COL_LSB), .COL_W(COL_W),
    .BANK_LSB(BANK_LSB), .BANK_W(BANK_W),
    .ROW_LSB(ROW_LSB), .ROW_W(ROW_W), .LINE_COL_BITS(LINE_COL_BITS)
  ) u_decode (
    .addr(req_addr), .bank(dec_bank), .row(dec_row), .col(dec_col)
  );

  lf_cmd_seq #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W),
    .BEATS(BEATS), .COL_STEP(COL_STEP)
  ) u_cmd (
    .clk(clk), .rst(rst), .start(start),
    .bank_in(dec_bank), .row_in(dec_row), .col_in(dec_col),
    .cmd_valid(cmd_valid), .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col)
  );

  lf_beat_gather #(
    .LANES(CHIPS), .LANE_W(CHIP_W), .BEATS(BEATS)
  ) u_gather (
    .clk(clk), .rst(rst), .start(start),
    .beat_valid(beat_valid), .beat_data(beat_data),
    .active(gather_active), .line_done(line_done), .line_data(line_data)
  );

  // R3
  start_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> cmd_valid && busy);
  // R8
  rise_from_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_valid) |-> $past(!busy));
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> !cmd_valid && !line_done && !busy);
endmodule

// File: tb/lf_line_fill_tb.sv
module lf_line_fill_tb;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0;
  logic [27:0]  req_addr = '0;
  logic         busy;
  logic         cmd_valid;
  logic [2:0]   cmd_bank;
  logic [13:0]  cmd_row;
  logic [10:0]  cmd_col;
  logic         beat_valid = 1'b0;
  logic [63:0]  beat_data = '0;
  logic         line_done;
  logic [511:0] line_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [27:0]  exp_cmd_q [$];
  logic [511:0] exp_line_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  lf_line_fill u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .busy(busy), .cmd_valid(cmd_valid), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
    .cmd_col(cmd_col), .beat_valid(beat_valid), .beat_data(beat_data),
    .line_done(line_done), .line_data(line_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [511:0] act,
                     input logic [511:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int id, input int n, input int k);
    return 8'((id * 37) ^ (n * 16) ^ (k * 3) ^ 8'h5A);
  endfunction

  // Monitor: compares commands and finished lines against queues
  bit prev_done = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (cmd_valid) begin
        if (exp_cmd_q.size() == 0) begin
          chk(1'b0, "R8 unexpected command", {cmd_row, cmd_bank, cmd_col}, '0);
        end else begin
          logic [27:0] e;
          e = exp_cmd_q.pop_front();
          chk({cmd_row, cmd_bank, cmd_col} == e, "R2/R4 command fields",
              {cmd_row, cmd_bank, cmd_col}, e);
        end
      end
      if (line_done) begin
        chk(!prev_done, "R6 done longer than one cycle", 1, 0);
        chk(!busy, "R6 busy low with done", busy, 0);
        if (exp_line_q.size() == 0) begin
          chk(1'b0, "R7 unexpected done", line_data, '0);
        end else begin
          logic [511:0] l;
          l = exp_line_q.pop_front();
          chk(line_data == l, "R5 line contents", line_data, l);
        end
      end
      prev_done = line_done;
    end
  end

  // Driver: one line fill; gap_mask selects idle cycles before beats,
  // intrude>=0 raises a second request on that beat
  task automatic do_fill(input logic [27:0] addr, input int id,
                         input int gap_mask, input int intrude);
    logic [511:0] line;
    logic [10:0]  col0;
    while (busy) @(negedge clk);
    col0 = {addr[10:6], 6'b0};
    for (int n = 0; n < 8; n++)
      exp_cmd_q.push_back({addr[27:14], addr[13:11], 11'(col0 + 11'(8*n))});
    for (int n = 0; n < 8; n++)
      for (int k = 0; k < 8; k++)
        line[64*n + 8*k +: 8] = pat(id, n, k);
    exp_line_q.push_back(line);
    req_valid = 1'b1;
    req_addr  = addr;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy && cmd_valid && cmd_col == col0, "R3 fill start",
        {busy, cmd_valid, cmd_col}, {2'b11, col0});
    for (int n = 0; n < 8; n++) begin
      if (gap_mask[n]) begin
        beat_valid = 1'b0;
        @(negedge clk);
      end
      for (int k = 0; k < 8; k++) beat_data[8*k +: 8] = pat(id, n, k);
      beat_valid = 1'b1;
      if (n == intrude) begin
        req_valid = 1'b1;
        req_addr  = addr ^ 28'h2AB_CDE0;
      end
      @(negedge clk);
      req_valid = 1'b0;
    end
    beat_valid = 1'b0;
    beat_data  = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(!busy && !cmd_valid && !line_done, "R1 reset state",
        {busy, cmd_valid, line_done}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !cmd_valid && !line_done, "R1 after release",
        {busy, cmd_valid, line_done}, 0);

    do_fill(28'h000_0000, 1, 0, -1);                // back-to-back beats
    do_fill(28'hABC_DEC0, 2, 8'b1010_0101, -1);     // gaps between beats
    do_fill(28'h5A5_A53F, 3, 0, -1);                // R2 low byte bits ignored
    do_fill(28'hFFF_FFC0, 4, 8'b0001_0000, 3);      // R8 request mid-fill
    @(negedge clk);
    @(negedge clk);
    // R7: beats while idle
    for (int i = 0; i < 3; i++) begin
      beat_valid = 1'b1;
      beat_data  = 64'hDEAD_BEEF_0000_0000 | 64'(i);
      @(negedge clk);
      chk(!line_done && !busy, "R7 idle beat ignored", {line_done, busy}, 0);
    end
    beat_valid = 1'b0;
    do_fill(28'h123_4567, 5, 8'b1000_0001, -1);     // R7 counter untouched
    do_fill(28'h3C0_07C0, 6, 8'b0100_0010, 0);      // R8 request on first beat
    repeat (4) @(negedge clk);
    chk(exp_cmd_q.size() == 0, "R4 all commands seen", exp_cmd_q.size(), 0);
    chk(exp_line_q.size() == 0, "R6 all lines done", exp_line_q.size(), 0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule